// File: doc/BRIEF.md
# First-Write Checkpoint Undo Logger

This block keeps the information needed to roll memory back to the most recent checkpoint. Each cache line has a one-bit "already-updated" flag. The first store to a line after a checkpoint copies that line's address and its data from before the store into an undo log, and then sets the flag. Later stores to the same line in the same interval are acknowledged without writing anything, because the value the line had at the checkpoint is already saved.

The log is split into a ring of checkpoint regions. A checkpoint pulse clears every flag and moves logging to the next region. When the ring wraps, the oldest region is emptied and used again. Regions that are not current keep their entries, and any region can be drained through a ready/valid port. The port selects a region and reads its entries in the order they were written. If the current region is full, the block raises an overflow flag and holds back stores that need a new entry. It releases them when a drain frees a slot or when a checkpoint starts a new region.

Top module: `undo_ckpt_logger`

## Requirements
- R1: When `st_valid_i` is high and the line's flag is clear, the block writes `st_addr_i` and `st_old_i` into the current region and raises `st_ack_o` in that same cycle. The entry can be drained from the next cycle.
- R2: A store to a line whose flag is already set in the current interval is acknowledged in the same cycle and adds no log entry.
- R3: A checkpoint clears every line flag, so the next store to any line is logged again.
- R4: Each checkpoint moves `cur_region_o` to (region + 1) modulo the region count, starting from 0. The region being entered is emptied when the ring wraps onto it.
- R5: Entries in regions other than the current one stay readable on the drain port until their region is reused.
- R6: `overflow_o` is high exactly when the current region holds as many entries as it has slots. While it is high and no checkpoint is present, a store that needs logging is not acknowledged and writes nothing.
- R7: Draining an entry from the full current region lowers `overflow_o` on the next cycle, and a stalled store then proceeds.
- R8: A store that arrives in the same cycle as a checkpoint is treated as coming after the checkpoint. It is logged into the new region and acknowledged, even if the old region is full.
- R9: A store that needs no logging is acknowledged even while `overflow_o` is high.
- R10: During and after reset, all regions are empty, all flags are clear, `cur_region_o` is 0 and `overflow_o` is low.
- R11: `drain_valid_o` is high when the region selected by `drain_region_i` is not empty. It shows that region's oldest entry, which is removed when `drain_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ckpt_i | input | 1 | Checkpoint pulse |
| st_valid_i | input | 1 | Store request valid |
| st_line_i | input | LINE_W (4) | Index of the cache line being stored to |
| st_addr_i | input | ADDR_W (16) | Line address to record |
| st_old_i | input | DATA_W (32) | Line data before the store |
| st_ack_o | output | 1 | Store accepted this cycle |
| overflow_o | output | 1 | Current region is full |
| cur_region_o | output | REG_W (2) | Region currently receiving entries |
| drain_region_i | input | REG_W (2) | Region selected for draining |
| drain_ready_i | input | 1 | Consumer takes the shown entry |
| drain_valid_o | output | 1 | Selected region holds an entry |
| drain_addr_o | output | ADDR_W (16) | Address of the oldest entry in the selected region |
| drain_data_o | output | DATA_W (32) | Saved data of that entry |

## Verification
The main function is exercised with several patterns. A run of stores to distinct lines shows that first updates append entries in order. Repeated stores to one line show that a hit adds no entry, because the drain sequence never contains a duplicate. Stores that push the current region past its capacity separate stalled first updates from hits that are still acknowledged. Checkpoints issued alone, and together with a store, show that the store goes to the new region, that older regions keep their contents, and that a region's contents disappear only when the ring wraps back onto it.

// File: rtl/ulog_pkg.sv
// Package ulog_pkg
// Shared types for the undo logger. Assumes nothing beyond IEEE 1800-2017.
package ulog_pkg;

    // Outcome of the store request in the current cycle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_LOG   = 2'd2,
        ST_STALL = 2'd3
    } st_kind_e;

endpackage

// File: rtl/ulog_flags.sv
// Module ulog_flags
// Keeps one already-updated bit per cache line. A set wins over a clear in
// the same cycle, so a store that arrives with a checkpoint marks its line
// in the new interval. Assumes set_idx_i < NUM_LINES.
module ulog_flags #(
    parameter int NUM_LINES = 16,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              set_i,
    input  logic [LINE_W-1:0] set_idx_i,
    input  logic [LINE_W-1:0] rd_idx_i,
    output logic              rd_flag_o
);

    logic [NUM_LINES-1:0] flags;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_flag
        // Per-line flag: reset, set on a logged store, cleared on a checkpoint
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (set_i && (set_idx_i == LINE_W'(g))) begin
                flags[g] <= 1'b1;
            end else if (clear_i) begin
                flags[g] <= 1'b0;
            end
        end
    end

    // Look up the flag of the line addressed by the store
    always_comb rd_flag_o = flags[rd_idx_i];

endmodule

// File: rtl/ulog_ring_ctrl.sv
// Module ulog_ring_ctrl
// Handles the ring of log regions. Each region has its own write pointer,
// read pointer and fill count. On a checkpoint the current region moves on,
// and the region being entered is emptied, or holds only the entry pushed
// in that same cycle. Assumes NUM_REGIONS and DEPTH are powers of two.
module ulog_ring_ctrl #(
    parameter int NUM_REGIONS = 4,
    parameter int DEPTH       = 4,
    localparam int REG_W = $clog2(NUM_REGIONS),
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ckpt_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [REG_W-1:0] pop_region_i,
    output logic [REG_W-1:0] cur_region_o,
    output logic [REG_W-1:0] push_region_o,
    output logic [PTR_W-1:0] push_slot_o,
    output logic [PTR_W-1:0] pop_slot_o,
    output logic             cur_full_o,
    output logic             pop_nonempty_o
);

    logic [REG_W-1:0] cur_q;
    logic [REG_W-1:0] next_region;
    logic [PTR_W-1:0] wptr [NUM_REGIONS];
    logic [PTR_W-1:0] rptr [NUM_REGIONS];
    logic [CNT_W-1:0] cnt  [NUM_REGIONS];

    // Region that becomes current at the next checkpoint
    always_comb next_region = cur_q + REG_W'(1);

    // Current region pointer: steps around the ring on every checkpoint
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (ckpt_i) begin
            cur_q <= next_region;
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic enter_g;
        logic push_g;
        logic pop_g;

        // Decode the events that touch this region
        always_comb begin
            enter_g = ckpt_i && (next_region == REG_W'(g));
            push_g  = push_i && (push_region_o == REG_W'(g));
            pop_g   = pop_i && (pop_region_i == REG_W'(g)) && !enter_g;
        end

        // Region bookkeeping: reuse empties it, otherwise push and pop move it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wptr[g] <= '0;
                rptr[g] <= '0;
                cnt[g]  <= '0;
            end else if (enter_g) begin
                wptr[g] <= PTR_W'(push_g);
                rptr[g] <= '0;
                cnt[g]  <= CNT_W'(push_g);
            end else begin
                if (push_g) wptr[g] <= wptr[g] + PTR_W'(1);
                if (pop_g)  rptr[g] <= rptr[g] + PTR_W'(1);
                cnt[g] <= cnt[g] + CNT_W'(push_g) - CNT_W'(pop_g);
            end
        end
    end

    // Where a push lands and what the drain port sees
    always_comb begin
        cur_region_o   = cur_q;
        push_region_o  = ckpt_i ? next_region : cur_q;
        push_slot_o    = ckpt_i ? '0 : wptr[cur_q];
        pop_slot_o     = rptr[pop_region_i];
        cur_full_o     = (cnt[cur_q] == CNT_W'(DEPTH));
        pop_nonempty_o = (cnt[pop_region_i] != '0);
    end

endmodule

// File: rtl/ulog_store.sv
// Module ulog_store
// Storage for the log entries: one write port and one combinational read
// port. The contents are not reset. Readers must only use slots that the
// ring controller reports as occupied.
module ulog_store #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [ADDR_W-1:0] raddr_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [ADDR_W-1:0] addr_mem [ENTRIES];
    logic [DATA_W-1:0] data_mem [ENTRIES];

    // Write one entry
    always_ff @(posedge clk) begin
        if (we_i) begin
            addr_mem[widx_i] <= waddr_i;
            data_mem[widx_i] <= wdata_i;
        end
    end

    // Read the entry at the head of the drained region
    always_comb begin
        raddr_o = addr_mem[ridx_i];
        rdata_o = data_mem[ridx_i];
    end

endmodule

// File: rtl/undo_ckpt_logger.sv
// Module undo_ckpt_logger (top)
// Saves the address and old data of a line on the first store to that line
// in each checkpoint interval. Entries go into a ring of checkpoint regions,
// and a ready/valid port drains any selected region. A checkpoint in the
// same cycle as a store is applied first. Assumes the store stays valid
// until it is acknowledged and that the region count and depth are powers
// of two.
module undo_ckpt_logger #(
    parameter int NUM_LINES    = 16,
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    parameter int NUM_REGIONS  = 4,
    parameter int REGION_DEPTH = 4,
    localparam int LINE_W  = $clog2(NUM_LINES),
    localparam int REG_W   = $clog2(NUM_REGIONS),
    localparam int PTR_W   = $clog2(REGION_DEPTH),
    localparam int ENTRIES = NUM_REGIONS * REGION_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ckpt_i,
    input  logic              st_valid_i,
    input  logic [LINE_W-1:0] st_line_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [DATA_W-1:0] st_old_i,
    output logic              st_ack_o,
    output logic              overflow_o,
    output logic [REG_W-1:0]  cur_region_o,
    input  logic [REG_W-1:0]  drain_region_i,
    input  logic              drain_ready_i,
    output logic              drain_valid_o,
    output logic [ADDR_W-1:0] drain_addr_o,
    output logic [DATA_W-1:0] drain_data_o
);
    import ulog_pkg::*;

    logic             line_flag;
    logic             cur_full;
    logic             pop_nonempty;
    logic [REG_W-1:0] push_region;
    logic [PTR_W-1:0] push_slot;
    logic [PTR_W-1:0] pop_slot;
    logic             push;
    logic             pop;
    st_kind_e         kind;

    ulog_flags #(.NUM_LINES(NUM_LINES)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (ckpt_i),
        .set_i     (push),
        .set_idx_i (st_line_i),
        .rd_idx_i  (st_line_i),
        .rd_flag_o (line_flag)
    );

    ulog_ring_ctrl #(.NUM_REGIONS(NUM_REGIONS), .DEPTH(REGION_DEPTH)) u_ring (
        .clk            (clk),
        .rst_n          (rst_n),
        .ckpt_i         (ckpt_i),
        .push_i         (push),
        .pop_i          (pop),
        .pop_region_i   (drain_region_i),
        .cur_region_o   (cur_region_o),
        .push_region_o  (push_region),
        .push_slot_o    (push_slot),
        .pop_slot_o     (pop_slot),
        .cur_full_o     (cur_full),
        .pop_nonempty_o (pop_nonempty)
    );

    ulog_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .we_i    (push),
        .widx_i  ({push_region, push_slot}),
        .waddr_i (st_addr_i),
        .wdata_i (st_old_i),
        .ridx_i  ({drain_region_i, pop_slot}),
        .raddr_o (drain_addr_o),
        .rdata_o (drain_data_o)
    );

    // Classify the store: a checkpoint this cycle means the flag no longer counts
    always_comb begin
        if (!st_valid_i)                 kind = ST_IDLE;
        else if (line_flag && !ckpt_i)   kind = ST_HIT;
        else if (cur_full && !ckpt_i)    kind = ST_STALL;
        else                             kind = ST_LOG;
    end

    // Handshakes and status toward the ports
    always_comb begin
        push          = (kind == ST_LOG);
        st_ack_o      = (kind == ST_LOG) || (kind == ST_HIT);
        overflow_o    = cur_full;
        drain_valid_o = pop_nonempty;
        pop           = pop_nonempty && drain_ready_i;
    end

endmodule

// File: rtl/undo_ckpt_logger_chk.sv
// Module undo_ckpt_logger_chk
// Port-level checks for undo_ckpt_logger, attached with bind. The widths
// follow the top module's default parameters.
module undo_ckpt_logger_chk #(
    parameter int REG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ckpt_i,
    input logic             st_valid_i,
    input logic             st_ack_o,
    input logic             overflow_o,
    input logic [REG_W-1:0] cur_region_o,
    input logic [REG_W-1:0] drain_region_i,
    input logic             drain_ready_i,
    input logic             drain_valid_o
);

    // R4: a checkpoint steps the region by one, modulo the ring size
    a_r4_region_step: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_i |=> (cur_region_o == REG_W'($past(cur_region_o) + 1)));

    // R4: without a checkpoint the region stays put
    a_r4_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ckpt_i |=> $stable(cur_region_o));

    // R8: a store that comes with a checkpoint is always accepted
    a_r8_ckpt_store_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_i && st_valid_i) |-> st_ack_o);

    // R1: no acknowledge without a request
    a_r1_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        st_ack_o |-> st_valid_i);

    // R6: a full region stays full unless drained or left by a checkpoint
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !ckpt_i &&
         !(drain_valid_o && drain_ready_i && drain_region_i == cur_region_o))
        |=> overflow_o);

    // R10: reset leaves region 0 current and no overflow
    a_r10_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cur_region_o == '0 && !overflow_o));

endmodule

bind undo_ckpt_logger undo_ckpt_logger_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ckpt_i         (ckpt_i),
    .st_valid_i     (st_valid_i),
    .st_ack_o       (st_ack_o),
    .overflow_o     (overflow_o),
    .cur_region_o   (cur_region_o),
    .drain_region_i (drain_region_i),
    .drain_ready_i  (drain_ready_i),
    .drain_valid_o  (drain_valid_o)
);

// File: tb/undo_ckpt_logger_bench.sv
// Bench for undo_ckpt_logger: a table of vectors followed by directed tests.
// Inputs change at the falling edge, and outputs are sampled 1 ns later.
module undo_ckpt_logger_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic        ckpt;
        logic        stv;
        logic [3:0]  line;
        logic        rdy;
        logic [1:0]  dreg;
        logic        e_ack;
        logic        e_ovf;
        logic        e_dv;
        logic [15:0] e_daddr;
    } vec_t;

    // Store address for step i is 0x1000 + 16*i + line. Old data is {0xDA7A, addr}.
    // Region depth 4, ring of 4.
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,4'd1,1'b0,2'd0, 1'b1,1'b0,1'b0,16'h0000}, // 0  R1 first store
        '{1'b0,1'b1,4'd1,1'b0,2'd0, 1'b1,1'b0,1'b1,16'h1001}, // 1  R2 hit, R11
        '{1'b0,1'b1,4'd2,1'b0,2'd0, 1'b1,1'b0,1'b1,16'h1001}, // 2  R1
        '{1'b0,1'b1,4'd3,1'b0,2'd0, 1'b1,1'b0,1'b1,16'h1001}, // 3  R1
        '{1'b0,1'b1,4'd4,1'b0,2'd0, 1'b1,1'b0,1'b1,16'h1001}, // 4  R1 fills region
        '{1'b0,1'b1,4'd5,1'b0,2'd0, 1'b0,1'b1,1'b1,16'h1001}, // 5  R6 stall
        '{1'b0,1'b1,4'd2,1'b0,2'd0, 1'b1,1'b1,1'b1,16'h1001}, // 6  R9 hit while full
        '{1'b0,1'b0,4'd0,1'b1,2'd0, 1'b0,1'b1,1'b1,16'h1001}, // 7  R11 drain pop
        '{1'b0,1'b1,4'd5,1'b0,2'd0, 1'b1,1'b0,1'b1,16'h1022}, // 8  R7 stall released
        '{1'b1,1'b1,4'd1,1'b0,2'd1, 1'b1,1'b1,1'b0,16'h0000}, // 9  R8 ckpt+store
        '{1'b0,1'b1,4'd1,1'b0,2'd1, 1'b1,1'b0,1'b1,16'h1091}, // 10 R8 in new region
        '{1'b0,1'b1,4'd2,1'b0,2'd0, 1'b1,1'b0,1'b1,16'h1022}, // 11 R3 relog, R5
        '{1'b1,1'b0,4'd0,1'b0,2'd1, 1'b0,1'b0,1'b1,16'h1091}, // 12 R4 ckpt
        '{1'b1,1'b0,4'd0,1'b0,2'd2, 1'b0,1'b0,1'b0,16'h0000}, // 13 R4 ckpt
        '{1'b1,1'b0,4'd0,1'b0,2'd0, 1'b0,1'b0,1'b1,16'h1022}, // 14 R5 kept until reuse
        '{1'b0,1'b0,4'd0,1'b0,2'd0, 1'b0,1'b0,1'b0,16'h0000}, // 15 R4 reused region empty
        '{1'b0,1'b1,4'd1,1'b0,2'd0, 1'b1,1'b0,1'b0,16'h0000}, // 16 R3 relog after ckpts
        '{1'b0,1'b0,4'd0,1'b0,2'd0, 1'b0,1'b0,1'b1,16'h1101}  // 17 R1 entry visible
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ckpt_i;
    logic        st_valid_i;
    logic [3:0]  st_line_i;
    logic [15:0] st_addr_i;
    logic [31:0] st_old_i;
    logic        st_ack_o;
    logic        overflow_o;
    logic [1:0]  cur_region_o;
    logic [1:0]  drain_region_i;
    logic        drain_ready_i;
    logic        drain_valid_o;
    logic [15:0] drain_addr_o;
    logic [31:0] drain_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    undo_ckpt_logger u_undo_ckpt_logger (
        .clk            (clk),
        .rst_n          (rst_n),
        .ckpt_i         (ckpt_i),
        .st_valid_i     (st_valid_i),
        .st_line_i      (st_line_i),
        .st_addr_i      (st_addr_i),
        .st_old_i       (st_old_i),
        .st_ack_o       (st_ack_o),
        .overflow_o     (overflow_o),
        .cur_region_o   (cur_region_o),
        .drain_region_i (drain_region_i),
        .drain_ready_i  (drain_ready_i),
        .drain_valid_o  (drain_valid_o),
        .drain_addr_o   (drain_addr_o),
        .drain_data_o   (drain_data_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ckpt_i = 1'b0; st_valid_i = 1'b0; st_line_i = '0; st_addr_i = '0;
        st_old_i = '0; drain_region_i = '0; drain_ready_i = 1'b0;
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        check("R10 overflow", 32'(overflow_o), 32'd0);
        check("R10 region", 32'(cur_region_o), 32'd0);
        check("R10 drain_valid", 32'(drain_valid_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ckpt_i         = VEC[i].ckpt;
            st_valid_i     = VEC[i].stv;
            st_line_i      = VEC[i].line;
            st_addr_i      = 16'h1000 + 16'(i * 16) + 16'(VEC[i].line);
            st_old_i       = {16'hDA7A, st_addr_i};
            drain_ready_i  = VEC[i].rdy;
            drain_region_i = VEC[i].dreg;
            #1;
            check($sformatf("R1/R2/R6/R9 ack step %0d", i), 32'(st_ack_o), 32'(VEC[i].e_ack));
            check($sformatf("R6/R7 overflow step %0d", i), 32'(overflow_o), 32'(VEC[i].e_ovf));
            check($sformatf("R5/R11 drain_valid step %0d", i), 32'(drain_valid_o), 32'(VEC[i].e_dv));
            if (VEC[i].e_dv)
                check($sformatf("R5/R11 drain_addr step %0d", i), 32'(drain_addr_o), 32'(VEC[i].e_daddr));
        end

        // R1: saved data matches the old data given with the store
        @(negedge clk);
        idle_inputs();
        #1;
        check("R1 drain_data", drain_data_o, 32'hDA7A_1101);
        // R4: four checkpoints wrapped the ring back to region 0
        check("R4 region wrap", 32'(cur_region_o), 32'd0);

        // R10: reset in the middle of activity empties the log
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 drain_valid after reset", 32'(drain_valid_o), 32'd0);
        check("R10 overflow after reset", 32'(overflow_o), 32'd0);

        // R3/R10: flags are clear after reset, so line 1 is logged again
        @(negedge clk);
        st_valid_i = 1'b1; st_line_i = 4'd1; st_addr_i = 16'h2001; st_old_i = 32'h1234_5678;
        #1;
        check("R10 ack after reset", 32'(st_ack_o), 32'd1);
        @(negedge clk);
        idle_inputs();
        #1;
        check("R10 relogged entry", 32'(drain_addr_o), 32'h2001);
        check("R1 relogged data", drain_data_o, 32'h1234_5678);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule